// File: doc/BRIEF.md
# Interval Timer

This block is a down-counting interval timer that sits behind a simple word-addressed register port. Software sets a reload limit, starts the timer, and receives a level interrupt each time the count runs out. An external prescaler provides a single-cycle tick-enable pulse. The counter moves one step on each pulse while the timer is running.

The timer has two modes, and software can switch between them at any time. In periodic mode, an expired counter takes the limit back on the following tick and keeps counting. In one-shot mode, the expiry also clears the run flag, so counting stops.

Software can load the count directly or through the limit, and it can read the count back at any time. The interrupt status is cleared by writing a one to it. An enable bit gates the status onto the interrupt pin. Two read-only words return an identification constant and the tick frequency; both are fixed when the block is elaborated.

Top module: `ivl_timer`

## Requirements
- R1: The register index is `addr[11:2]`. The indices are:
  - 0: identification
  - 1: run
  - 2: one-shot
  - 3: limit
  - 4: count
  - 5: interrupt enable
  - 6: interrupt status
  - 7: frequency

  A read of any other index returns 0.
- R2: Index 0 reads the `ID_VAL` parameter and index 7 reads the `FREQ_VAL` parameter. Writes to either index change nothing.
- R3: A nonzero write to run starts the timer and a zero write stops it. Run reads back as 1 or 0. While stopped, the count holds its value.
- R4: While running, each cycle with `tick_en` high lowers the count by exactly one.
- R5: A tick that takes the count from 1 to 0 sets interrupt status bit 0. A running counter at 0 loads the limit on its next tick.
- R6: A nonzero write to one-shot selects one-shot mode, and this can happen while running. In one-shot mode, an expiry also clears run on the same clock edge.
- R7: A limit write stores the value and loads it into the count on the same edge.
- R8: A count write loads the count and leaves the limit unchanged. Reading index 4 returns the live count.
- R9: Writing status with data bit 0 set clears the status bit; a write with bit 0 clear leaves it unchanged. An expiry on the same edge wins over the clear.
- R10: `irq_o` is high exactly when status bit 0 and enable bit 0 (the enable register's data bit 0) are both set.
- R11: With limit 0 and count 0, a running timer stays at 0 and never expires.
- R12: Reset clears run, one-shot, limit, count, enable and status, so `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count-enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Byte address within the register window |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr` (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker verifies several behaviours on every cycle:
- A limit write loads both the limit and the count.
- A 1-to-0 tick sets the status.
- A one-shot expiry drops run.
- A stopped counter holds its value.
- A zero limit with a zero count stays idle.
- A status clear or an enable drop pulls the interrupt low.

Only the bench scenarios can show the rest:
- the read values of every index, including the fixed words and unmapped indices;
- the extra reload tick in each periodic period;
- switching mode while running;
- a clear and an expiry landing on the same edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int NREG = 8;

  typedef enum logic [2:0] {
    IX_IDENT = 3'd0,
    IX_RUN   = 3'd1,
    IX_ONE   = 3'd2,
    IX_LIM   = 3'd3,
    IX_CNT   = 3'd4,
    IX_IEN   = 3'd5,
    IX_STAT  = 3'd6,
    IX_FREQ  = 3'd7
  } reg_ix_e;
endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode
  import ivl_timer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_sel,
  output logic              in_map,
  output reg_ix_e           ix
);
  localparam int IX_W = ADDR_W - 2;

  logic [IX_W-1:0] word_ix;

  assign word_ix = addr[ADDR_W-1:2];
  assign in_map  = (word_ix < IX_W'(NREG));
  assign ix      = reg_ix_e'(word_ix[2:0]);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = wr_en && in_map && (word_ix[2:0] == 3'(g));
  end
endmodule

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_sel,
  input  logic [DW-1:0]   wdata,
  input  logic            expire,
  output logic            run_q,
  output logic            one_q,
  output logic            ien_q,
  output logic            stat_q,
  output logic [DW-1:0]   lim_q
);
  logic          run_d, one_d, ien_d, stat_d;
  logic [DW-1:0] lim_d;
  logic          flag_en, lim_en;

  assign flag_en = (|wr_sel) || expire;
  assign lim_en  = wr_sel[IX_LIM];

  always_comb begin
    run_d  = run_q;
    one_d  = one_q;
    ien_d  = ien_q;
    stat_d = stat_q;
    lim_d  = lim_q;
    if (expire && one_q)                 run_d  = 1'b0;
    if (wr_sel[IX_RUN])                  run_d  = |wdata;
    if (wr_sel[IX_ONE])                  one_d  = |wdata;
    if (wr_sel[IX_IEN])                  ien_d  = wdata[0];
    if (wr_sel[IX_STAT] && wdata[0])     stat_d = 1'b0;
    if (expire)                          stat_d = 1'b1;
    if (wr_sel[IX_LIM])                  lim_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      one_q  <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
    end else if (flag_en) begin
      run_q  <= run_d;
      one_q  <= one_d;
      ien_q  <= ien_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end
endmodule

// File: rtl/ivl_timer_counter.sv
module ivl_timer_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic          ld_lim,
  input  logic          ld_cnt,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lim,
  output logic [DW-1:0] cnt_q,
  output logic          expire
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_d;
  logic          cnt_en;
  logic          step;

  assign step   = tick_en && run;
  assign cnt_en = ld_lim || ld_cnt || step;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (ld_lim || ld_cnt) begin
      cnt_d = wdata;
    end else if (step) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - ONE;
        expire = (cnt_q == ONE);
      end else begin
        cnt_d  = lim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VAL   = 32'hC0DE_7100,
  parameter logic [31:0] FREQ_VAL = 32'd1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_o
);
  logic [NREG-1:0] wr_sel;
  logic            in_map;
  reg_ix_e         ix;
  logic            run_q, one_q, ien_q, stat_q, expire;
  logic [DW-1:0]   lim_q, cnt_q;

  ivl_timer_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wr_sel(wr_sel),
    .in_map(in_map),
    .ix    (ix)
  );

  ivl_timer_ctrl #(.DW(DW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sel(wr_sel),
    .wdata (wdata),
    .expire(expire),
    .run_q (run_q),
    .one_q (one_q),
    .ien_q (ien_q),
    .stat_q(stat_q),
    .lim_q (lim_q)
  );

  ivl_timer_counter #(.DW(DW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .run    (run_q),
    .ld_lim (wr_sel[IX_LIM]),
    .ld_cnt (wr_sel[IX_CNT]),
    .wdata  (wdata),
    .lim    (lim_q),
    .cnt_q  (cnt_q),
    .expire (expire)
  );

  assign irq_o = stat_q && ien_q;

  always_comb begin
    rdata = '0;
    if (in_map) begin
      unique case (ix)
        IX_IDENT: rdata = DW'(ID_VAL);
        IX_RUN:   rdata = DW'(run_q);
        IX_ONE:   rdata = DW'(one_q);
        IX_LIM:   rdata = lim_q;
        IX_CNT:   rdata = cnt_q;
        IX_IEN:   rdata = DW'(ien_q);
        IX_STAT:  rdata = DW'(stat_q);
        IX_FREQ:  rdata = DW'(FREQ_VAL);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic              irq_o,
  input logic              run,
  input logic              one,
  input logic              stat,
  input logic [DW-1:0]     lim,
  input logic [DW-1:0]     cnt
);
  logic [ADDR_W-3:0] wix;
  logic              wr_load, wr_run, last_tick;

  assign wix       = addr[ADDR_W-1:2];
  assign wr_load   = wr_en && (wix == (ADDR_W-2)'(3) || wix == (ADDR_W-2)'(4));
  assign wr_run    = wr_en && (wix == (ADDR_W-2)'(1));
  assign last_tick = tick_en && run && (cnt == DW'(1)) && !wr_load;

  // R7
  lim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wix == (ADDR_W-2)'(3)) |=> (cnt == $past(wdata) && lim == $past(wdata)));

  // R5
  expire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> stat);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && one && !wr_run) |=> !run);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_load) |=> $stable(cnt));

  // R11
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && lim == '0 && !wr_load) |=> (cnt == '0 && !$rose(stat)));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wix == (ADDR_W-2)'(6) && wdata[0] && !last_tick) |=> (!stat && !irq_o));

  // R10
  ien_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wix == (ADDR_W-2)'(5) && !wdata[0]) |=> !irq_o);
endmodule

bind ivl_timer ivl_timer_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_en(tick_en),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .irq_o  (irq_o),
  .run    (run_q),
  .one    (one_q),
  .stat   (stat_q),
  .lim    (lim_q),
  .cnt    (cnt_q)
);

// File: tb/ivl_timer_bench.sv
`timescale 1ns/1ps
module ivl_timer_bench;
  localparam logic [31:0] IDV = 32'hC0DE_7100;
  localparam logic [31:0] FQV = 32'd1_000_000;
  localparam int NV = 12;
  // {write idx, write data, check idx, expected}
  localparam logic [69:0] VEC [NV] = '{
    {3'd3, 32'd5,          3'd4, 32'd5},   // R7 limit loads count
    {3'd3, 32'd5,          3'd3, 32'd5},   // R7 limit stored
    {3'd4, 32'd3,          3'd3, 32'd5},   // R8 limit unchanged
    {3'd4, 32'd3,          3'd4, 32'd3},   // R8 count loaded
    {3'd0, 32'hFFFF_FFFF,  3'd0, IDV},     // R2 ident ignored
    {3'd7, 32'd0,          3'd7, FQV},     // R2 freq ignored
    {3'd5, 32'd1,          3'd5, 32'd1},   // R1 enable
    {3'd1, 32'd7,          3'd1, 32'd1},   // R3 nonzero run
    {3'd1, 32'd0,          3'd1, 32'd0},   // R3 zero run
    {3'd2, 32'd4,          3'd2, 32'd1},   // R6 one-shot set
    {3'd2, 32'd0,          3'd2, 32'd0},   // R6 one-shot clear
    {3'd5, 32'd0,          3'd5, 32'd0}    // R1 enable clear
  };

  logic        clk, rst_n, tick_en, wr_en, irq_o;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  ivl_timer u_ivl_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] ix, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {ix, 2'b00}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] ix, output logic [31:0] d);
    addr = {ix, 2'b00};
    #1 d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rchk(input string req, input logic [9:0] ix, input logic [31:0] exp);
    logic [31:0] v;
    rd(ix, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int i = 1; i < 7; i++) rchk("R12", 10'(i), 32'd0);
    chk("R12 irq", 32'(irq_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(10'(VEC[i][69:67]), VEC[i][66:35]);
      rchk($sformatf("vec%0d", i), 10'(VEC[i][34:32]), VEC[i][31:0]);
    end
    rchk("R1 unmapped", 10'd9, 32'd0);

    // R4/R5 periodic counting
    wr(10'd5, 32'd1); wr(10'd3, 32'd3); wr(10'd1, 32'd1);
    tick(1); rchk("R4", 10'd4, 32'd2);
    tick(1); rchk("R4", 10'd4, 32'd1);
    tick(1); rchk("R5 zero", 10'd4, 32'd0);
    rchk("R5 status", 10'd6, 32'd1);
    chk("R10 irq on", 32'(irq_o), 32'd1);
    tick(1); rchk("R5 reload", 10'd4, 32'd3);

    // R9 write-one-to-clear
    wr(10'd6, 32'd0); rchk("R9 keep", 10'd6, 32'd1);
    wr(10'd6, 32'd1); rchk("R9 clear", 10'd6, 32'd0);
    chk("R10 irq off", 32'(irq_o), 32'd0);

    // R3 stop holds count
    tick(1); wr(10'd1, 32'd0); tick(2);
    rchk("R3 hold", 10'd4, 32'd2);

    // R10 enable gating
    wr(10'd5, 32'd0); wr(10'd1, 32'd1); tick(2);
    rchk("R10 status", 10'd6, 32'd1);
    chk("R10 masked", 32'(irq_o), 32'd0);
    wr(10'd5, 32'd1);
    chk("R10 unmask", 32'(irq_o), 32'd1);
    wr(10'd6, 32'd1);

    // R6 one-shot selected while running
    wr(10'd2, 32'd1);
    tick(1); rchk("R6 reload", 10'd4, 32'd3);
    tick(3); rchk("R6 run off", 10'd1, 32'd0);
    rchk("R6 status", 10'd6, 32'd1);
    tick(2); rchk("R6 stopped", 10'd4, 32'd0);

    // R11 zero limit idle
    wr(10'd6, 32'd1); wr(10'd2, 32'd0); wr(10'd3, 32'd0); wr(10'd1, 32'd1);
    tick(3);
    rchk("R11 count", 10'd4, 32'd0);
    rchk("R11 status", 10'd6, 32'd0);

    // R9 expiry beats clear on the same edge
    wr(10'd3, 32'd2); tick(1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = {10'd6, 2'b00}; wdata = 32'd1;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rchk("R9 expiry wins", 10'd6, 32'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule